// File: doc/BRIEF.md
# Leakage-Speed Cell State Recovery

This block repairs a multi-level-cell page word that has decayed past the point where the error-correcting code can cope. The two highest programmed states drift together as charge leaks away. Cells near their shared boundary cannot be resolved from a single read. For each cell, the block receives the two-bit code read at the optimal boundary. It also receives three sense flags: two from the first read, taken one sigma below and one sigma above that boundary, and one from a second read at the lower level, taken after the page has aged further.

A cell that sits between the two sigma levels in the first read is ambiguous. For such a cell, the block uses the drop between the two reads to judge how fast it leaks. A fast leaker started higher and is rewritten as the upper state. A slow leaker is rewritten as the lower state. Every other cell passes through untouched. The aim is to cut the raw error count roughly in half, so that the downstream decoder can correct the rest.

Words stream through at one per cycle, with valid/ready handshaking on both sides and a single register stage. Each output word carries a count of the cells whose code the block changed.

Top module: `leak_state_recover`

## Requirements
- R1: After reset, and until the first word is accepted, `out_valid` is 0.
- R2: A cell is ambiguous only when its `in_above_lo` bit is 1 and its `in_above_hi` bit is 0. Any other cell leaves the block with its input code unchanged.
- R3: Cell i's code occupies bits [2i+1:2i]. Bit 2i+1 is the upper-page bit and bit 2i is the lower-page bit. The lower of the two top states is code 2'b00 and the highest state is code 2'b01.
- R4: An ambiguous cell whose `in_later_lo` bit is 1 has stayed above the lower level, so it is a slow leaker. Its output code is 2'b00.
- R5: An ambiguous cell whose `in_later_lo` bit is 0 has dropped below the lower level, so it is a fast leaker. Its output code is 2'b01.
- R6: `out_fixed` equals the number of cells in the word whose output code differs from the input code.
- R7: A word accepted on a clock edge (`in_valid` and `in_ready` both 1) is presented on `out_valid`/`out_code` after that edge. With no new word and the output free or consumed, `out_valid` drops.
- R8: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_code` and `out_fixed` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can take a word |
| in_code | input | 2*CELLS | Two-bit codes read at the optimal boundary |
| in_above_lo | input | CELLS | First read: cell above boundary minus sigma |
| in_above_hi | input | CELLS | First read: cell above boundary plus sigma |
| in_later_lo | input | CELLS | Later read: cell still above boundary minus sigma |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the word |
| out_code | output | 2*CELLS | Repaired two-bit codes |
| out_fixed | output | $clog2(CELLS+1) | Count of cells rewritten in this word |

## Verification
The bench sweeps every combination of code and sense flags through each cell position. This catches a swapped fast/slow mapping, which would invert the repair and double the errors rather than halve them. It also catches a loose ambiguity test that touches cells above the upper sigma level. Ambiguous cells that already hold the target code are included as well; a design that counted ambiguous cells instead of changed cells would over-report `out_fixed` on those. A stalled output is probed to confirm that a second word is neither accepted nor allowed to overwrite the held one.

// File: rtl/leak_state_recover.sv
module leak_state_recover #(
  parameter int CELLS = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  output logic                           in_ready,
  input  logic [2*CELLS-1:0]             in_code,
  input  logic [CELLS-1:0]               in_above_lo,
  input  logic [CELLS-1:0]               in_above_hi,
  input  logic [CELLS-1:0]               in_later_lo,
  output logic                           out_valid,
  input  logic                           out_ready,
  output logic [2*CELLS-1:0]             out_code,
  output logic [$clog2(CELLS+1)-1:0]     out_fixed
);
  localparam int CW = $clog2(CELLS + 1);
  localparam logic [1:0] LOW_TOP  = 2'b00;
  localparam logic [1:0] HIGH_TOP = 2'b01;

  logic [2*CELLS-1:0] fix_code;
  logic [CELLS-1:0]   changed;
  logic [CW-1:0]      fix_cnt;

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    wire       risky = in_above_lo[i] & ~in_above_hi[i];
    wire [1:0] guess = in_later_lo[i] ? LOW_TOP : HIGH_TOP;
    assign fix_code[2*i +: 2] = risky ? guess : in_code[2*i +: 2];
    assign changed[i] = fix_code[2*i +: 2] != in_code[2*i +: 2];
  end

  always_comb begin
    fix_cnt = '0;
    for (int i = 0; i < CELLS; i++) fix_cnt = fix_cnt + CW'(changed[i]);
  end

  assign in_ready = ~out_valid | out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_code  <= '0;
      out_fixed <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_code  <= fix_code;
        out_fixed <= fix_cnt;
      end
    end
  end
endmodule

module leak_state_recover_chk #(
  parameter int CELLS = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic                       in_ready,
  input logic                       out_valid,
  input logic                       out_ready,
  input logic [2*CELLS-1:0]         out_code,
  input logic [$clog2(CELLS+1)-1:0] out_fixed
);
  // R8
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_code) && $stable(out_fixed));
  // R7
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
  // R7
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && (!out_valid || out_ready) |=> !out_valid);
  // R6
  fixed_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_fixed <= CELLS);
endmodule

bind leak_state_recover leak_state_recover_chk #(.CELLS(CELLS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_code(out_code),
  .out_fixed(out_fixed)
);

// File: tb/test_leak_state_recover.sv
module test_leak_state_recover;
  localparam int CELLS = 4;
  localparam int CW = $clog2(CELLS + 1);

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 1;
  logic [2*CELLS-1:0] in_code = '0;
  logic [CELLS-1:0] in_above_lo = '0, in_above_hi = '0, in_later_lo = '0;
  logic in_ready, out_valid;
  logic [2*CELLS-1:0] out_code;
  logic [CW-1:0] out_fixed;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  leak_state_recover #(.CELLS(CELLS)) i_leak_state_recover (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_code(in_code), .in_above_lo(in_above_lo), .in_above_hi(in_above_hi),
    .in_later_lo(in_later_lo), .out_valid(out_valid), .out_ready(out_ready),
    .out_code(out_code), .out_fixed(out_fixed));

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // cell pattern p[4:0]: {later, hi, lo, code[1:0]}
  function automatic logic [1:0] exp_cell(input int p);
    logic [1:0] c = p[1:0];
    if (p[2] && !p[3]) return p[4] ? 2'b00 : 2'b01;  // R4 / R5
    return c;                                        // R2
  endfunction

  task automatic load(input int pats[CELLS]);
    for (int c = 0; c < CELLS; c++) begin
      in_code[2*c +: 2] = pats[c][1:0];
      in_above_lo[c]    = pats[c][2];
      in_above_hi[c]    = pats[c][3];
      in_later_lo[c]    = pats[c][4];
    end
  endtask

  function automatic int exp_word(input int pats[CELLS]);
    int w = 0;
    for (int c = 0; c < CELLS; c++) w |= int'(exp_cell(pats[c])) << (2*c);
    return w;
  endfunction

  function automatic int exp_cnt(input int pats[CELLS]);
    int n = 0;
    for (int c = 0; c < CELLS; c++) if (exp_cell(pats[c]) != pats[c][1:0]) n++;
    return n;
  endfunction

  initial begin
    int pa[CELLS];
    int pb[CELLS];
    repeat (3) @(negedge clk);
    check("R1", out_valid, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1", out_valid, 0);

    // R2 R3 R4 R5 R6 R7: every pattern in every cell position
    for (int k = 0; k < 32 * CELLS; k++) begin
      for (int c = 0; c < CELLS; c++) pa[c] = (k + c * (k / 32 + 5) * 7) % 32;
      for (int c = 0; c < CELLS; c++) if (c == k / 32) pa[c] = k % 32;
      load(pa);
      in_valid = 1;
      @(posedge clk);
      @(negedge clk);
      check("R7", out_valid, 1);
      check("R2_R4_R5", int'(out_code), exp_word(pa));
      check("R6", int'(out_fixed), exp_cnt(pa));
    end
    in_valid = 0;
    @(posedge clk);
    @(negedge clk);
    check("R7", out_valid, 0);

    // R8: stall holds the word and refuses the next one
    for (int c = 0; c < CELLS; c++) begin pa[c] = 5 + c; pb[c] = 20 + c; end
    out_ready = 0;
    load(pa);
    in_valid = 1;
    @(posedge clk);
    @(negedge clk);
    load(pb);
    check("R8", in_ready, 0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R8", int'(out_code), exp_word(pa));
    check("R8", int'(out_fixed), exp_cnt(pa));
    out_ready = 1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    check("R8", int'(out_code), exp_word(pb));
    check("R6", int'(out_fixed), exp_cnt(pb));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule